// File: doc/BRIEF.md
# Single/Quad SPI Byte Shifter

This block is the master-side bit engine for a serial flash link. Each transfer request moves exactly one byte. The chosen mode decides how the byte travels:

- **Single-lane mode** is full duplex. It sends on D0 and receives on D1, eight clock pulses per byte.
- **Quad-lane mode** is half duplex. It uses all four data lines, two clock pulses per byte, and the direction is either transmit or receive.

The block generates the serial clock from a programmable half-period divider. It holds chip select low between a begin request and an end request, so a command sequencer above it can chain as many bytes as a flash command needs.

The block owns six pins and drives both the output value and the output enable of each one. Pin indices are 0 CLK, 1 CS (active low), 2 D0, 3 D1, 4 D2 (write protect), 5 D3 (hold). Each mode has its own pin-direction pattern, and the enables only change while the serial clock is low.

A pass-through input hands CLK, CS, D0 and D1 over to another owner, while D2 and D3 stay driven.

Top module: `qspi_byte_shifter`

## Requirements
- R1: After reset, pin_o is 6'b110010 (CS high, CLK low, D2 and D3 high) and pin_oe is 6'b110111. busy and done are 0.
- R2: Requests are accepted only while busy is 0 and passthru is 0. If several arrive together, the priority is begin, then transfer, then end.
  - An accepted begin drives CS low on the next cycle. When mode_quad is 0, it also drives D2 and D3 high and selects the single-lane pin pattern.
  - An accepted end drives CS high.
  - Requests that arrive while busy is 1 have no effect.
- R3: A single-lane transfer (mode_quad=0, dir_rx=0) produces 8 CLK pulses.
  - tx_byte goes out MSB first on D0, with each bit stable before and during its high phase.
  - D1 is sampled at the end of each high phase, MSB first, and the result is on rx_byte when done rises.
- R4: A single-lane receive-only transfer (mode_quad=0, dir_rx=1) drives D0 high for all 8 bits, regardless of tx_byte.
- R5: A quad transmit (mode_quad=1, dir_rx=0) produces 2 CLK pulses and sets pin_oe to 6'b111111.
  - The high nibble goes first.
  - Within a nibble, D3 carries the most significant bit and D0 the least.
- R6: A quad receive (mode_quad=1, dir_rx=1) sets pin_oe to 6'b000011 and samples D3..D0 at the end of each of 2 high phases, high nibble first. rx_byte holds the result when done rises.
- R7: Let H = half_div+1. Each CLK pulse is H cycles low followed by H cycles high.
  - busy rises at the accepting edge.
  - done is a one-cycle pulse that rises 2*H*N cycles after that edge, where N is 8 in single-lane mode and 2 in quad mode.
- R8: pin_oe never changes while CLK is high, and CLK is high only while busy.
- R9: While passthru is 1 and the block is idle, pin_oe becomes 6'b110000 from the next cycle. D2 and D3 keep their values, and all requests are ignored.
- R10: CS does not change while a byte is in progress, so it stays low across consecutive bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_begin | input | 1 | Assert chip select |
| req_end | input | 1 | Release chip select |
| req_xfer | input | 1 | Start a one-byte transfer |
| mode_quad | input | 1 | 0 single-lane, 1 quad-lane |
| dir_rx | input | 1 | 1 receive (quad input lines, or single with all-ones transmit) |
| passthru | input | 1 | Release CLK, CS, D0, D1 to another owner |
| half_div | input | DIV_W | Clock half-period minus one, in clk cycles |
| tx_byte | input | 8 | Byte to send |
| pin_i | input | 4 | Input values of D3..D0 |
| pin_o | output | 6 | Output values {D3, D2, D1, D0, CS, CLK} |
| pin_oe | output | 6 | Output enables, same order as pin_o |
| rx_byte | output | 8 | Received byte, valid when done is high |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a byte |

## Verification
A transfer is accepted at the clock edge where req_xfer is seen. busy reads 1 just after that edge, and done is due exactly 2*(half_div+1)*N edges later, with N being 8 or 2. The bench counts edges from acceptance to the first done and compares the count with that product. It samples every port at the falling system-clock edge, half a cycle away from any change.

Pin data is captured at each rising serial clock edge. The flash model advances its bit index at each falling serial clock edge, which comes after the design has already sampled. CS, pass-through and enable changes are due one edge after the request, and are checked at the next falling system-clock edge.

// File: rtl/qspi_byte_shifter.sv
module qspi_byte_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_begin,
  input  logic             req_end,
  input  logic             req_xfer,
  input  logic             mode_quad,
  input  logic             dir_rx,
  input  logic             passthru,
  input  logic [DIV_W-1:0] half_div,
  input  logic [7:0]       tx_byte,
  input  logic [3:0]       pin_i,
  output logic [5:0]       pin_o,
  output logic [5:0]       pin_oe,
  output logic [7:0]       rx_byte,
  output logic             busy,
  output logic             done
);

  localparam logic [5:0] OE_SINGLE = 6'b110111;
  localparam logic [5:0] OE_QTX    = 6'b111111;
  localparam logic [5:0] OE_QRX    = 6'b000011;
  localparam logic [5:0] OE_PASS   = 6'b110000;

  typedef enum logic [1:0] {PM_SINGLE, PM_QTX, PM_QRX} pin_mode_t;

  pin_mode_t        pm;
  logic             pass_q, act, sclk, ncs, quad_q, done_q;
  logic [3:0]       dout;
  logic [7:0]       sh;
  logic [DIV_W-1:0] hcnt, hdiv_q;
  logic [2:0]       left;

  wire       idle_ok  = !act && !passthru;
  wire       go_begin = idle_ok && req_begin;
  wire       go_xfer  = idle_ok && !req_begin && req_xfer;
  wire       go_end   = idle_ok && !req_begin && !req_xfer && req_end;
  wire       tick     = act && (hcnt == '0);
  wire [7:0] tx_eff   = (!mode_quad && dir_rx) ? 8'hFF : tx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm     <= PM_SINGLE;
      pass_q <= 1'b0;
      act    <= 1'b0;
      sclk   <= 1'b0;
      ncs    <= 1'b1;
      quad_q <= 1'b0;
      done_q <= 1'b0;
      dout   <= 4'b1100;
      sh     <= '0;
      hcnt   <= '0;
      hdiv_q <= '0;
      left   <= '0;
    end else begin
      done_q <= tick && sclk && (left == 3'd0);
      if (!act) pass_q <= passthru;
      if (go_begin) begin
        ncs <= 1'b0;
        pm  <= PM_SINGLE;
        if (!mode_quad) dout[3:2] <= 2'b11;
      end
      if (go_end) ncs <= 1'b1;
      if (go_xfer) begin
        act    <= 1'b1;
        sclk   <= 1'b0;
        hcnt   <= half_div;
        hdiv_q <= half_div;
        quad_q <= mode_quad;
        if (mode_quad) begin
          pm   <= dir_rx ? PM_QRX : PM_QTX;
          left <= 3'd1;
          sh   <= {tx_eff[3:0], 4'b0000};
          if (!dir_rx) dout <= tx_eff[7:4];
        end else begin
          pm      <= PM_SINGLE;
          left    <= 3'd7;
          sh      <= {tx_eff[6:0], 1'b0};
          dout[0] <= tx_eff[7];
        end
      end
      if (act) begin
        if (hcnt != '0) begin
          hcnt <= hcnt - 1'b1;
        end else begin
          hcnt <= hdiv_q;
          sclk <= !sclk;
          if (sclk) begin
            sh <= quad_q ? {sh[3:0], pin_i} : {sh[6:0], pin_i[1]};
            if (left == 3'd0) begin
              act <= 1'b0;
            end else begin
              left <= left - 3'd1;
              if (!quad_q) dout[0] <= sh[7];
              else if (pm == PM_QTX) dout <= sh[7:4];
            end
          end
        end
      end
    end
  end

  always_comb begin
    if (pass_q) pin_oe = OE_PASS;
    else begin
      case (pm)
        PM_QTX:  pin_oe = OE_QTX;
        PM_QRX:  pin_oe = OE_QRX;
        default: pin_oe = OE_SINGLE;
      endcase
    end
  end

  assign pin_o   = {dout, ncs, sclk};
  assign rx_byte = sh;
  assign busy    = act;
  assign done    = done_q;

  a_r8_oe_still_when_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    pin_o[0] |-> $stable(pin_oe));

  a_r8_sclk_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pin_o[0] |-> busy);

  a_r10_cs_steady_in_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pin_o[1]));

  a_r7_done_closes_byte: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r9_pass_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(passthru) && !$past(busy) && !busy) |-> (pin_oe == OE_PASS));

endmodule

// File: tb/tb_qspi_byte_shifter.sv
module tb_qspi_byte_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_begin = 0, req_end = 0, req_xfer = 0, mode_quad = 0, dir_rx = 0, passthru = 0;
  logic [7:0] half_div = 0;
  logic [7:0] tx_byte = 0;
  logic [3:0] pin_i;
  logic [5:0] pin_o, pin_oe;
  logic [7:0] rx_byte;
  logic busy, done;

  int n_chk = 0, n_bad = 0;
  int idx = 0, pulses = 0;
  logic [7:0] pat = 0, cap = 0;
  logic [5:0] oe_seen = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  qspi_byte_shifter #(.DIV_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_begin(req_begin), .req_end(req_end), .req_xfer(req_xfer),
    .mode_quad(mode_quad), .dir_rx(dir_rx), .passthru(passthru), .half_div(half_div),
    .tx_byte(tx_byte), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .rx_byte(rx_byte),
    .busy(busy), .done(done));

  wire sclk = pin_o[0];

  always_comb begin
    if (mode_quad) pin_i = (idx == 0) ? pat[7:4] : pat[3:0];
    else           pin_i = {2'b00, (idx < 8) ? pat[7 - idx] : 1'b0, 1'b0};
  end

  always @(posedge sclk) begin
    pulses  = pulses + 1;
    oe_seen = pin_oe;
    if (mode_quad) cap = {cap[3:0], pin_o[5:2]};
    else           cap = {cap[6:0], pin_o[2]};
  end

  always @(negedge sclk) idx = idx + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic q, input logic r, input int hd, input logic [7:0] tx,
                      input logic [7:0] p);
    int cyc;
    int nb;
    nb = q ? 2 : 8;
    @(negedge clk);
    half_div = 8'(hd); mode_quad = q; dir_rx = r; tx_byte = tx; pat = p;
    idx = 0; pulses = 0; cap = 0; req_xfer = 1;
    @(posedge clk);
    @(negedge clk);
    req_xfer = 0;
    chk("R7 busy after accept", busy, 1);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk); @(negedge clk); cyc++;
    end
    chk("R7 cycles to done", cyc, 2 * (hd + 1) * nb);
    chk("R10 CS low at done", pin_o[1], 0);
    if (!q) begin
      chk("R3 pulse count", pulses, 8);
      chk("R3 single oe", oe_seen, 6'b110111);
      if (r) chk("R4 all-ones on D0", cap, 8'hFF);
      else   chk("R3 D0 bits", cap, tx);
      chk("R3 rx byte", rx_byte, p);
    end else if (!r) begin
      chk("R5 pulse count", pulses, 2);
      chk("R5 quad tx oe", oe_seen, 6'b111111);
      chk("R5 nibble order", cap, tx);
    end else begin
      chk("R6 pulse count", pulses, 2);
      chk("R6 quad rx oe", oe_seen, 6'b000011);
      chk("R6 rx byte", rx_byte, p);
    end
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
  endtask

  task automatic pulse_req(input logic b, input logic e, input logic x, input logic q);
    @(negedge clk);
    req_begin = b; req_end = e; req_xfer = x; mode_quad = q;
    @(negedge clk);
    req_begin = 0; req_end = 0; req_xfer = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pins", pin_o, 6'b110010);
    chk("R1 oe", pin_oe, 6'b110111);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);

    pulse_req(1, 0, 0, 0);
    chk("R2 begin drops CS", pin_o[1], 0);

    for (int hd = 0; hd < 3; hd++)
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 6; k++)
          xfer(m[1], m[0], hd, 8'((k * 53 + hd * 17 + m * 29 + 7) & 255),
               8'((~(k * 53 + hd * 17 + m * 29 + 7) ^ (k * 11)) & 255));

    xfer(1, 0, 0, 8'h30, 8'h00);
    chk("R5 last nibble on D3/D2", pin_o[5:4], 2'b00);
    pulse_req(1, 0, 0, 0);
    chk("R2 begin raises WP/HOLD", pin_o[5:4], 2'b11);
    chk("R2 begin single oe", pin_oe, 6'b110111);

    @(negedge clk);
    half_div = 3; mode_quad = 0; dir_rx = 0; tx_byte = 8'hA5; pat = 8'h3C;
    idx = 0; pulses = 0; req_xfer = 1;
    @(negedge clk);
    req_xfer = 0; req_end = 1;
    @(negedge clk);
    req_end = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R2 end ignored while busy", pin_o[1], 0);

    pulse_req(0, 1, 0, 0);
    chk("R2 end raises CS", pin_o[1], 1);
    pulse_req(1, 1, 0, 0);
    chk("R2 begin beats end", pin_o[1], 0);

    @(negedge clk);
    passthru = 1;
    @(negedge clk);
    chk("R9 pass oe", pin_oe, 6'b110000);
    chk("R9 WP/HOLD kept", pin_o[5:4], 2'b11);
    req_xfer = 1; req_end = 1;
    @(negedge clk);
    @(negedge clk);
    req_xfer = 0; req_end = 0;
    chk("R9 xfer ignored", busy, 0);
    chk("R9 end ignored", pin_o[1], 0);
    passthru = 0;
    @(negedge clk);
    chk("R9 pins reclaimed", pin_oe, 6'b110111);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule